// File: doc/BRIEF.md
# Privileged CSR Access Unit

This block holds the control and status registers of a processor core and carries out the three privileged register instructions against them. A read returns a register's value. A write stores new data and returns the value it replaces. An exchange changes only the bits picked by a mask and returns the prior value. Every request carries the current privilege level. A request from user level is refused with an illegal-privilege exception.

A request is one cycle wide and is qualified by `req_valid`. Exactly one cycle later the unit presents a registered response. The response holds the data for the destination register, an illegal-privilege flag and a read-only trap flag. It also holds a flush request, which tells the pipeline that translation or mode state has just changed.

Registers not listed below read as zero and silently ignore writes. The identity register and the configuration registers are constants fixed at elaboration. Registers whose writes have side effects elsewhere in a core, such as the timer, exception status and address-space identifier, are plain storage here.

Top module: `csr_access_unit`

## Requirements
- R1: A read (`req_op` = 0) of a writable register returns its stored value and raises no exception, trap or flush.
- R2: A write (`req_op` = 1) returns the register's previous contents and stores `req_wdata` in the same operation.
- R3: An exchange (`req_op` = 2) stores (`req_wdata` AND `req_mask`) OR (old AND NOT `req_mask`) and returns the old value.
- R4: Any request at `req_priv` = 3 (user) raises `rsp_priv_exc` with zero data and no trap or flush, and changes no register. This exception takes priority over the read-only trap.
- R5: Addresses that are not implemented read as zero. A write or exchange to such an address returns zero, stores nothing and raises no trap.
- R6: The identity register at 0x020 (default 0x00000007) and the configuration registers at 0x021, 0x022 and 0x023 (defaults 0x00010010, 0x00020020, 0x00030030) can be read. A write or exchange to any of them raises `rsp_ro_trap`, returns zero and changes nothing.
- R7: `rsp_flush` is raised after a completed write or exchange to the mode register (0x000), the unit-enable register (0x002), the exception-status register (0x005) or the address-space register (0x018). It is never raised after a read, and never for other registers.
- R8: There are sixteen scratch registers at 0x030 to 0x03F and four mapping-window registers at 0x180 to 0x183. Each has its own storage, and an access to one leaves the others unchanged.
- R9: Every response appears exactly one cycle after its request, with `rsp_valid` high. Without a request, all response outputs are zero in the next cycle.
- R10: Reset clears all writable registers to zero, except the mode register, which resets to 0x00000008 (kernel privilege, translation off). Reset also clears all response outputs.
- R11: Operation code 3 behaves exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 read |
| req_addr | input | 14 | Register number |
| req_wdata | input | XLEN | Write data |
| req_mask | input | XLEN | Exchange bit mask |
| req_priv | input | 2 | Current privilege level, where 3 is user |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN | Value for the destination register |
| rsp_priv_exc | output | 1 | Illegal-privilege exception |
| rsp_ro_trap | output | 1 | Write to a read-only register |
| rsp_flush | output | 1 | Pipeline flush request |

## Verification
A corrupted register shows up at `rsp_rdata` as soon as a read, write or exchange returns that register's old value, one cycle after the request. A wrong decode of an address class shows up in that same response cycle, as a trap, a flush or zero data that should not be there. The merge of the exchange operation is checked with a mask that has both set and clear bits in every byte. A read-back follows in the next request, so an error in either half of the merge is visible within two requests.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int ADDR_W = 14;

  typedef enum logic [1:0] {
    CSR_OP_RD     = 2'd0,
    CSR_OP_WR     = 2'd1,
    CSR_OP_XCHG   = 2'd2,
    CSR_OP_RD_ALT = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_USER = 2'd3;

  // Fixed single registers (writable)
  localparam logic [ADDR_W-1:0] A_MODE    = 14'h000;
  localparam logic [ADDR_W-1:0] A_PREV    = 14'h001;
  localparam logic [ADDR_W-1:0] A_UNITEN  = 14'h002;
  localparam logic [ADDR_W-1:0] A_EXCCFG  = 14'h004;
  localparam logic [ADDR_W-1:0] A_EXCSTAT = 14'h005;
  localparam logic [ADDR_W-1:0] A_RETADDR = 14'h006;
  localparam logic [ADDR_W-1:0] A_BADADDR = 14'h007;
  localparam logic [ADDR_W-1:0] A_ENTRY   = 14'h00C;
  localparam logic [ADDR_W-1:0] A_ASID    = 14'h018;
  // Constant registers
  localparam logic [ADDR_W-1:0] A_CPUID   = 14'h020;
  localparam logic [ADDR_W-1:0] A_CFG1    = 14'h021;
  localparam logic [ADDR_W-1:0] A_CFG2    = 14'h022;
  localparam logic [ADDR_W-1:0] A_CFG3    = 14'h023;

  // Storage slots of the single writable registers
  localparam int N_SINGLE = 9;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_pkg::*;
#(
  parameter int                XLEN      = 32,
  parameter int                NSAVE     = 16,
  parameter int                NWIN      = 4,
  parameter int                SAVE_BASE = 'h030,
  parameter int                WIN_BASE  = 'h180,
  parameter int                IDX_W     = 5,
  parameter logic [XLEN-1:0]   CPUID_VAL = 32'h0000_0007,
  parameter logic [XLEN-1:0]   CFG1_VAL  = 32'h0001_0010,
  parameter logic [XLEN-1:0]   CFG2_VAL  = 32'h0002_0020,
  parameter logic [XLEN-1:0]   CFG3_VAL  = 32'h0003_0030
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              ro,
  output logic              flush_attr,
  output logic [IDX_W-1:0]  idx,
  output logic [XLEN-1:0]   ro_val
);
  localparam int WIN_SLOT0 = N_SINGLE + NSAVE;

  logic            save_hit, win_hit;
  logic [IDX_W-1:0] save_idx, win_idx;

  // Banked register groups: range decode per parameterised bank
  always_comb begin
    save_hit = (int'(addr) >= SAVE_BASE) && (int'(addr) < SAVE_BASE + NSAVE);
    win_hit  = (int'(addr) >= WIN_BASE)  && (int'(addr) < WIN_BASE + NWIN);
    save_idx = IDX_W'(N_SINGLE + int'(addr) - SAVE_BASE);
    win_idx  = IDX_W'(WIN_SLOT0 + int'(addr) - WIN_BASE);
  end

  always_comb begin
    hit        = 1'b1;
    ro         = 1'b0;
    flush_attr = 1'b0;
    idx        = '0;
    ro_val     = '0;
    unique case (addr)
      A_MODE:    begin idx = IDX_W'(0); flush_attr = 1'b1; end
      A_PREV:    idx = IDX_W'(1);
      A_UNITEN:  begin idx = IDX_W'(2); flush_attr = 1'b1; end
      A_EXCCFG:  idx = IDX_W'(3);
      A_EXCSTAT: begin idx = IDX_W'(4); flush_attr = 1'b1; end
      A_RETADDR: idx = IDX_W'(5);
      A_BADADDR: idx = IDX_W'(6);
      A_ENTRY:   idx = IDX_W'(7);
      A_ASID:    begin idx = IDX_W'(8); flush_attr = 1'b1; end
      A_CPUID:   begin ro = 1'b1; ro_val = CPUID_VAL; end
      A_CFG1:    begin ro = 1'b1; ro_val = CFG1_VAL; end
      A_CFG2:    begin ro = 1'b1; ro_val = CFG2_VAL; end
      A_CFG3:    begin ro = 1'b1; ro_val = CFG3_VAL; end
      default: begin
        if (save_hit) begin
          idx = save_idx;
        end else if (win_hit) begin
          idx = win_idx;
        end else begin
          hit = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
  parameter int              XLEN     = 32,
  parameter int              NREGS    = 29,
  parameter int              IDX_W    = 5,
  parameter logic [XLEN-1:0] MODE_RST = 32'h0000_0008
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data
);
  logic [XLEN-1:0] regs [NREGS];

  assign rd_data = (int'(rd_idx) < NREGS) ? regs[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) begin
        regs[i] <= (i == 0) ? MODE_RST : '0;
      end
    end else if (we && (int'(wr_idx) < NREGS)) begin
      regs[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/csr_merge.sv
module csr_merge
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] new_val
);
  always_comb begin
    if (op == CSR_OP_XCHG) begin
      new_val = (wdata & mask) | (old_val & ~mask);
    end else begin
      new_val = wdata;
    end
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              NSAVE     = 16,
  parameter int              NWIN      = 4,
  parameter int              SAVE_BASE = 'h030,
  parameter int              WIN_BASE  = 'h180,
  parameter logic [XLEN-1:0] MODE_RST  = 32'h0000_0008,
  parameter logic [XLEN-1:0] CPUID_VAL = 32'h0000_0007,
  parameter logic [XLEN-1:0] CFG1_VAL  = 32'h0001_0010,
  parameter logic [XLEN-1:0] CFG2_VAL  = 32'h0002_0020,
  parameter logic [XLEN-1:0] CFG3_VAL  = 32'h0003_0030
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [13:0]       req_addr,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [XLEN-1:0]   req_mask,
  input  logic [1:0]        req_priv,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_priv_exc,
  output logic              rsp_ro_trap,
  output logic              rsp_flush
);
  localparam int NREGS = N_SINGLE + NSAVE + NWIN;
  localparam int IDX_W = $clog2(NREGS);

  logic             hit, ro, flush_attr;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  ro_val, old_val, new_val;

  csr_addr_decode #(
    .XLEN(XLEN), .NSAVE(NSAVE), .NWIN(NWIN), .SAVE_BASE(SAVE_BASE),
    .WIN_BASE(WIN_BASE), .IDX_W(IDX_W), .CPUID_VAL(CPUID_VAL),
    .CFG1_VAL(CFG1_VAL), .CFG2_VAL(CFG2_VAL), .CFG3_VAL(CFG3_VAL)
  ) dec_i (
    .addr(req_addr), .hit(hit), .ro(ro), .flush_attr(flush_attr),
    .idx(idx), .ro_val(ro_val)
  );

  logic is_user, is_write, do_access, priv_exc, ro_trap, wr_en, flush_n;
  logic [XLEN-1:0] rdata_n;

  always_comb begin
    is_user   = (req_priv == PRIV_USER);
    is_write  = (req_op == CSR_OP_WR) || (req_op == CSR_OP_XCHG);
    priv_exc  = req_valid && is_user;
    do_access = req_valid && !is_user;
    ro_trap   = do_access && hit && ro && is_write;
    wr_en     = do_access && hit && !ro && is_write;
    flush_n   = wr_en && flush_attr;
    if (!do_access || !hit || ro_trap) begin
      rdata_n = '0;
    end else if (ro) begin
      rdata_n = ro_val;
    end else begin
      rdata_n = old_val;
    end
  end

  csr_merge #(.XLEN(XLEN)) merge_i (
    .op(req_op), .old_val(old_val), .wdata(req_wdata), .mask(req_mask),
    .new_val(new_val)
  );

  csr_regfile #(
    .XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W), .MODE_RST(MODE_RST)
  ) rf_i (
    .clk(clk), .rst(rst), .rd_idx(idx), .rd_data(old_val),
    .we(wr_en), .wr_idx(idx), .wr_data(new_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_priv_exc <= 1'b0;
      rsp_ro_trap  <= 1'b0;
      rsp_flush    <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_rdata    <= rdata_n;
      rsp_priv_exc <= priv_exc;
      rsp_ro_trap  <= ro_trap;
      rsp_flush    <= flush_n;
    end
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [1:0]      req_priv,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_rdata,
  input logic            rsp_priv_exc,
  input logic            rsp_ro_trap,
  input logic            rsp_flush
);
  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_rdata == '0 && !rsp_priv_exc &&
                    !rsp_ro_trap && !rsp_flush));

  a_r4_user_excepts: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == 2'd3) |=>
      (rsp_priv_exc && rsp_rdata == '0 && !rsp_ro_trap && !rsp_flush));

  a_r7_read_no_flush: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 2'd0 || req_op == 2'd3)) |=> !rsp_flush);

  a_r6_trap_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_ro_trap |-> (rsp_rdata == '0 && !rsp_flush && !rsp_priv_exc));
endmodule

bind csr_access_unit csr_access_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_priv_exc(rsp_priv_exc), .rsp_ro_trap(rsp_ro_trap),
  .rsp_flush(rsp_flush)
);

// File: tb/csr_access_unit_tb.sv
module csr_access_unit_tb_top;
  localparam int XLEN = 32;
  localparam int VW   = 2 + 14 + 32 + 32 + 2 + 32 + 3;
  localparam int NV   = 34;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = '0;
  logic [13:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic [31:0]     req_mask = '0;
  logic [1:0]      req_priv = '0;
  logic            rsp_valid, rsp_priv_exc, rsp_ro_trap, rsp_flush;
  logic [31:0]     rsp_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_priv_exc(rsp_priv_exc), .rsp_ro_trap(rsp_ro_trap),
    .rsp_flush(rsp_flush)
  );

  function automatic logic [VW-1:0] v(logic [1:0] op, logic [13:0] a,
      logic [31:0] wd, logic [31:0] mk, logic [1:0] pv, logic [31:0] ex,
      logic e, logic t, logic f);
    return {op, a, wd, mk, pv, ex, e, t, f};
  endfunction

  localparam logic [VW-1:0] VTAB [NV] = '{
    v(2'd0, 14'h000, 32'h0,        32'h0,        2'd0, 32'h8,        1'b0, 1'b0, 1'b0), // 0
    v(2'd0, 14'h030, 32'h0,        32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 1
    v(2'd1, 14'h033, 32'hA5A50001, 32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 2
    v(2'd0, 14'h033, 32'h0,        32'h0,        2'd0, 32'hA5A50001, 1'b0, 1'b0, 1'b0), // 3
    v(2'd2, 14'h033, 32'hFFFF0000, 32'h0F0FF0F0, 2'd0, 32'hA5A50001, 1'b0, 1'b0, 1'b0), // 4
    v(2'd0, 14'h033, 32'h0,        32'h0,        2'd0, 32'hAFAF0001, 1'b0, 1'b0, 1'b0), // 5
    v(2'd1, 14'h03F, 32'h12345678, 32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 6
    v(2'd0, 14'h03F, 32'h0,        32'h0,        2'd0, 32'h12345678, 1'b0, 1'b0, 1'b0), // 7
    v(2'd0, 14'h030, 32'h0,        32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 8
    v(2'd1, 14'h018, 32'h55,       32'h0,        2'd1, 32'h0,        1'b0, 1'b0, 1'b1), // 9
    v(2'd0, 14'h018, 32'h0,        32'h0,        2'd1, 32'h55,       1'b0, 1'b0, 1'b0), // 10
    v(2'd2, 14'h000, 32'h1,        32'h3,        2'd0, 32'h8,        1'b0, 1'b0, 1'b1), // 11
    v(2'd0, 14'h000, 32'h0,        32'h0,        2'd0, 32'h9,        1'b0, 1'b0, 1'b0), // 12
    v(2'd1, 14'h001, 32'h77,       32'h0,        2'd2, 32'h0,        1'b0, 1'b0, 1'b0), // 13
    v(2'd1, 14'h005, 32'hABCD,     32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b1), // 14
    v(2'd1, 14'h020, 32'h1,        32'h0,        2'd0, 32'h0,        1'b0, 1'b1, 1'b0), // 15
    v(2'd2, 14'h021, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0), // 16
    v(2'd0, 14'h020, 32'h0,        32'h0,        2'd0, 32'h7,        1'b0, 1'b0, 1'b0), // 17
    v(2'd0, 14'h021, 32'h0,        32'h0,        2'd0, 32'h00010010, 1'b0, 1'b0, 1'b0), // 18
    v(2'd0, 14'h023, 32'h0,        32'h0,        2'd0, 32'h00030030, 1'b0, 1'b0, 1'b0), // 19
    v(2'd1, 14'h3FFF, 32'hFFFFFFFF, 32'h0,       2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 20
    v(2'd0, 14'h3FFF, 32'h0,       32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 21
    v(2'd2, 14'h040, 32'h1,        32'h1,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 22
    v(2'd0, 14'h040, 32'h0,        32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 23
    v(2'd1, 14'h030, 32'hDEAD,     32'h0,        2'd3, 32'h0,        1'b1, 1'b0, 1'b0), // 24
    v(2'd0, 14'h030, 32'h0,        32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 25
    v(2'd0, 14'h033, 32'h0,        32'h0,        2'd3, 32'h0,        1'b1, 1'b0, 1'b0), // 26
    v(2'd1, 14'h020, 32'h1,        32'h0,        2'd3, 32'h0,        1'b1, 1'b0, 1'b0), // 27
    v(2'd1, 14'h183, 32'hCAFE,     32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 28
    v(2'd0, 14'h183, 32'h0,        32'h0,        2'd0, 32'hCAFE,     1'b0, 1'b0, 1'b0), // 29
    v(2'd0, 14'h184, 32'h0,        32'h0,        2'd0, 32'h0,        1'b0, 1'b0, 1'b0), // 30
    v(2'd3, 14'h033, 32'h0,        32'h0,        2'd0, 32'hAFAF0001, 1'b0, 1'b0, 1'b0), // 31
    v(2'd1, 14'h000, 32'h8,        32'h0,        2'd0, 32'h9,        1'b0, 1'b0, 1'b1), // 32
    v(2'd0, 14'h022, 32'h0,        32'h0,        2'd0, 32'h00020020, 1'b0, 1'b0, 1'b0)  // 33
  };

  string vtag [NV] = '{
    "R10", "R10", "R2", "R1", "R3", "R3", "R8", "R8", "R8", "R7",
    "R7", "R7", "R3", "R7", "R7", "R6", "R6", "R6", "R6", "R6",
    "R5", "R5", "R5", "R5", "R4", "R4", "R4", "R4", "R8", "R8",
    "R5", "R11", "R2", "R6"
  };

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive on a falling edge; the response is registered at the next rising
  // edge and sampled on the falling edge after it.
  task automatic issue(logic [1:0] op, logic [13:0] a, logic [31:0] wd,
                       logic [31:0] mk, logic [1:0] pv);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    req_wdata = wd; req_mask = mk; req_priv = pv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: outputs cleared after reset
    check("R10", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check("R10", "rsp_rdata after reset", rsp_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VTAB[i];
      issue(e[116:115], e[114:101], e[100:69], e[68:37], e[36:35]);
      check(vtag[i], $sformatf("vec %0d rdata", i), rsp_rdata, e[34:3]);
      check(vtag[i], $sformatf("vec %0d priv_exc", i), 32'(rsp_priv_exc), 32'(e[2]));
      check(vtag[i], $sformatf("vec %0d ro_trap", i), 32'(rsp_ro_trap), 32'(e[1]));
      check(vtag[i], $sformatf("vec %0d flush", i), 32'(rsp_flush), 32'(e[0]));
      check("R9", $sformatf("vec %0d rsp_valid", i), 32'(rsp_valid), 32'h1);
    end

    // R9: idle cycle produces an all-zero response
    @(negedge clk);
    check("R9", "idle rsp_valid", 32'(rsp_valid), 32'h0);
    check("R9", "idle rsp_rdata", rsp_rdata, 32'h0);

    // R10: reset in mid-run restores the defaults
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst = 1'b0;
    issue(2'd0, 14'h033, 32'h0, 32'h0, 2'd0);
    check("R10", "scratch cleared", rsp_rdata, 32'h0);
    issue(2'd0, 14'h000, 32'h0, 32'h0, 2'd0);
    check("R10", "mode reset value", rsp_rdata, 32'h8);
    issue(2'd0, 14'h183, 32'h0, 32'h0, 2'd0);
    check("R10", "window cleared", rsp_rdata, 32'h0);
    issue(2'd0, 14'h018, 32'h0, 32'h0, 2'd0);
    check("R10", "asid cleared", rsp_rdata, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule